// File: doc/BRIEF.md
# Command-coded output line bank

This block sits behind one 32-bit register and drives a small bank of output lines. Each line has its own multi-bit command field in the register. Software does not write the output level directly. It writes a command code into the line's field. One code turns the line on and another turns it off. Every other code leaves the line where it was.

Because of this coding, one register write can change any subset of lines and leave the rest alone. Software only has to put a neutral code, such as zero, into the fields it does not want to touch.

The following are all parameters: the number of lines, the field width, the bit offset of the first field, the two command codes, and the level each line takes at reset. The bus side is a single write strobe with write data, plus a read-data vector that reflects the last write.

Top module: `cmd_gpio_bank`

## Requirements
- R1: When `wr_en` is high at a rising edge and a line's field holds the activate code (2 by default), that line's output is 1 after that edge.
- R2: When `wr_en` is high at a rising edge and a line's field holds the deactivate code (3 by default), that line's output is 0 after that edge.
- R3: When a line's field holds any other code (0 or 1 by default), that line's output keeps its previous level through the write.
- R4: Line n is controlled by bits `[FIRST_SHIFT + n*FIELD_W +: FIELD_W]`. With the defaults, line 0 uses bits 6:5 and line 1 uses bits 8:7. Each line responds only to its own field.
- R5: Register bits outside every line field have no effect on any output. With the defaults, these are bits 4:0 and 31:9.
- R6: When `wr_en` is low, all outputs hold their levels whatever `wr_data` carries.
- R7: A synchronous active-high `rst` sets every output to its reset level (both lines 1 by default) and clears `rd_data` to zero.
- R8: After each write, `rd_data` equals the written word with every bit outside the line fields forced to zero. With the defaults, that is the word ANDed with 0x0000_01E0.
- R9: When `rst` and `wr_en` are both high at the same edge, the reset wins and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the command register |
| wr_data | input | REG_W | Command word |
| rd_data | output | REG_W | Last written word, limited to the field bits |
| lines_out | output | LINE_CNT | Output line levels |

## Verification
The bench starts from each of the four possible output states and writes every pair of field codes: 16 combinations per state. Set, clear and neutral codes are told apart on each line, and the result shows whether one line's command ever leaks into the other. Every such write also carries a different noise pattern in the bits outside the fields, which would expose a field placed off by one or an unused bit that is decoded. Idle cycles with scrambled write data, and a reset asserted together with a write, separate holding and reset priority from ordinary command handling.

// File: rtl/cmdgpio_pkg.sv
package cmdgpio_pkg;

   typedef enum logic [1:0] {
      CMD_HOLD = 2'd0,
      CMD_SET  = 2'd1,
      CMD_CLR  = 2'd2
   } line_cmd_e;

   // bit mask covering all command fields of the bank
   function automatic logic [63:0] field_mask(input int first, input int width, input int count);
      logic [63:0] m;
      m = '0;
      for (int b = 0; b < 64; b++) begin
         if (b >= first && b < first + width * count) m[b] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/cmdgpio_decode.sv
module cmdgpio_decode
   import cmdgpio_pkg::*;
#(
   parameter int FIELD_W  = 2,
   parameter int SET_CODE = 2,
   parameter int CLR_CODE = 3
) (
   input  logic               strobe,
   input  logic [FIELD_W-1:0] field,
   output line_cmd_e          cmd
);
   localparam logic [FIELD_W-1:0] SET_F = FIELD_W'(SET_CODE);
   localparam logic [FIELD_W-1:0] CLR_F = FIELD_W'(CLR_CODE);

   always_comb begin
      cmd = CMD_HOLD;
      if (strobe) begin
         if (field == SET_F)      cmd = CMD_SET;
         else if (field == CLR_F) cmd = CMD_CLR;
      end
   end
endmodule

// File: rtl/cmdgpio_line.sv
module cmdgpio_line
   import cmdgpio_pkg::*;
#(
   parameter logic RST_LVL = 1'b1
) (
   input  logic      clk,
   input  logic      rst,
   input  line_cmd_e cmd,
   output logic      level
);
   always_ff @(posedge clk) begin
      if (rst) begin
         level <= RST_LVL;
      end else begin
         unique case (cmd)
            CMD_SET: level <= 1'b1;
            CMD_CLR: level <= 1'b0;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/cmdgpio_readback.sv
module cmdgpio_readback #(
   parameter int             REG_W = 32,
   parameter logic [REG_W-1:0] MASK  = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data
);
   always_ff @(posedge clk) begin
      if (rst)        rd_data <= '0;
      else if (wr_en) rd_data <= wr_data & MASK;
   end
endmodule

// File: rtl/cmd_gpio_bank.sv
module cmd_gpio_bank
   import cmdgpio_pkg::*;
#(
   parameter int                  REG_W       = 32,
   parameter int                  LINE_CNT    = 2,
   parameter int                  FIELD_W     = 2,
   parameter int                  FIRST_SHIFT = 5,
   parameter int                  SET_CODE    = 2,
   parameter int                  CLR_CODE    = 3,
   parameter logic [LINE_CNT-1:0] RST_LEVELS  = '1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic [REG_W-1:0]    wr_data,
   output logic [REG_W-1:0]    rd_data,
   output logic [LINE_CNT-1:0] lines_out
);
   localparam int               TOP_BIT = FIRST_SHIFT + LINE_CNT * FIELD_W;
   localparam logic [REG_W-1:0] FLD_MASK = REG_W'(field_mask(FIRST_SHIFT, FIELD_W, LINE_CNT));

   // elaboration-time parameter checks
   if (TOP_BIT > REG_W) begin : g_bad_span
      $error("command fields exceed register width");
   end
   if (SET_CODE == CLR_CODE) begin : g_bad_codes
      $error("activate and deactivate codes must differ");
   end
   if (SET_CODE >= (1 << FIELD_W) || CLR_CODE >= (1 << FIELD_W)) begin : g_bad_code_w
      $error("command code does not fit field width");
   end
   if (LINE_CNT < 1 || FIELD_W < 1 || REG_W > 64) begin : g_bad_dims
      $error("unsupported bank dimensions");
   end

   for (genvar n = 0; n < LINE_CNT; n++) begin : g_line
      line_cmd_e cmd;

      cmdgpio_decode #(
         .FIELD_W (FIELD_W),
         .SET_CODE(SET_CODE),
         .CLR_CODE(CLR_CODE)
      ) u_dec (
         .strobe(wr_en),
         .field (wr_data[FIRST_SHIFT + n*FIELD_W +: FIELD_W]),
         .cmd   (cmd)
      );

      cmdgpio_line #(
         .RST_LVL(RST_LEVELS[n])
      ) u_line (
         .clk  (clk),
         .rst  (rst),
         .cmd  (cmd),
         .level(lines_out[n])
      );
   end

   cmdgpio_readback #(
      .REG_W(REG_W),
      .MASK (FLD_MASK)
   ) u_rb (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .rd_data(rd_data)
   );
endmodule

// File: rtl/cmd_gpio_bank_chk.sv
module cmd_gpio_bank_chk
   import cmdgpio_pkg::*;
#(
   parameter int                  REG_W       = 32,
   parameter int                  LINE_CNT    = 2,
   parameter int                  FIELD_W     = 2,
   parameter int                  FIRST_SHIFT = 5,
   parameter int                  SET_CODE    = 2,
   parameter int                  CLR_CODE    = 3,
   parameter logic [LINE_CNT-1:0] RST_LEVELS  = '1
) (
   input logic                clk,
   input logic                rst,
   input logic                wr_en,
   input logic [REG_W-1:0]    wr_data,
   input logic [REG_W-1:0]    rd_data,
   input logic [LINE_CNT-1:0] lines_out
);
   localparam logic [REG_W-1:0]   MASK  = REG_W'(field_mask(FIRST_SHIFT, FIELD_W, LINE_CNT));
   localparam logic [FIELD_W-1:0] SET_F = FIELD_W'(SET_CODE);
   localparam logic [FIELD_W-1:0] CLR_F = FIELD_W'(CLR_CODE);

   logic rst_q = 1'b0;
   always_ff @(posedge clk) rst_q <= rst;

   // R7 R9
   always @(posedge clk) begin
      if (rst_q) begin
         rst_level_chk: assert (lines_out == RST_LEVELS && rd_data == '0);
      end
   end

   // R8
   rd_unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_data & ~MASK) == '0);

   // R8
   rd_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> rd_data == ($past(wr_data) & MASK));

   for (genvar n = 0; n < LINE_CNT; n++) begin : g_chk
      // R1 R4
      set_line_chk: assert property (@(posedge clk) disable iff (rst)
         (wr_en && wr_data[FIRST_SHIFT + n*FIELD_W +: FIELD_W] == SET_F) |=> lines_out[n]);

      // R2 R4
      clr_line_chk: assert property (@(posedge clk) disable iff (rst)
         (wr_en && wr_data[FIRST_SHIFT + n*FIELD_W +: FIELD_W] == CLR_F) |=> !lines_out[n]);

      // R3 R5 R6
      hold_line_chk: assert property (@(posedge clk) disable iff (rst)
         !(wr_en && (wr_data[FIRST_SHIFT + n*FIELD_W +: FIELD_W] == SET_F ||
                     wr_data[FIRST_SHIFT + n*FIELD_W +: FIELD_W] == CLR_F))
         |=> $stable(lines_out[n]));
   end
endmodule

bind cmd_gpio_bank cmd_gpio_bank_chk #(
   .REG_W      (REG_W),
   .LINE_CNT   (LINE_CNT),
   .FIELD_W    (FIELD_W),
   .FIRST_SHIFT(FIRST_SHIFT),
   .SET_CODE   (SET_CODE),
   .CLR_CODE   (CLR_CODE),
   .RST_LEVELS (RST_LEVELS)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .lines_out(lines_out)
);

// File: tb/cmd_gpio_bank_test.sv
module cmd_gpio_bank_test;
   localparam logic [31:0] MASK = 32'h0000_01E0;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [1:0]  lines_out;

   int n_checks = 0;
   int n_fail   = 0;
   logic [1:0]  exp_lines;
   logic [31:0] exp_rd;

   always #2 clk = ~clk;

   cmd_gpio_bank uut (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .lines_out(lines_out)
   );

   function automatic logic next_lvl(input logic [1:0] code, input logic prev);
      if (code == 2'd2) return 1'b1;
      if (code == 2'd3) return 1'b0;
      return prev;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // write on one edge, update model, compare after the edge
   task automatic do_write(input logic [31:0] d, input string tag);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      exp_lines[0] = next_lvl(d[6:5], exp_lines[0]);
      exp_lines[1] = next_lvl(d[8:7], exp_lines[1]);
      exp_rd = d & MASK;
      @(negedge clk);
      wr_en = 1'b0;
      check({tag, " lines"}, {30'd0, lines_out}, {30'd0, exp_lines});
      check({tag, " R8 readback"}, rd_data, exp_rd);
   endtask

   initial begin
      #40000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      exp_lines = 2'b11;
      exp_rd    = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R7 reset state
      check("R7 reset lines", {30'd0, lines_out}, 32'd3);
      check("R7 reset readback", rd_data, 32'd0);

      // exhaustive sweep: 4 start states x 16 code pairs, noise outside fields
      for (int s = 0; s < 4; s++) begin
         for (int c0 = 0; c0 < 4; c0++) begin
            for (int c1 = 0; c1 < 4; c1++) begin
               logic [31:0] noise;
               logic [31:0] setup;
               noise = (32'hA5A5_5A5A ^ (32'(s*16 + c0*4 + c1) * 32'h0101_0107)) & ~MASK;
               setup = {23'd0, (s[1] ? 2'd2 : 2'd3), (s[0] ? 2'd2 : 2'd3), 5'd0};
               do_write(setup, "R1 R2 setup");
               do_write(noise | {23'd0, 2'(c1), 2'(c0), 5'd0}, "R1 R2 R3 R4 R5 sweep");
            end
         end
      end

      // R6: idle cycles with scrambled data keep outputs
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         wr_en   = 1'b0;
         wr_data = 32'hFFFF_FFFF ^ (32'(k) << 5);
         @(negedge clk);
         check("R6 idle hold", {30'd0, lines_out}, {30'd0, exp_lines});
         check("R6 idle readback", rd_data, exp_rd);
      end

      // R5: only unused bits set, all ones
      do_write(32'hFFFF_FE1F, "R5 unused only");

      // R9: reset together with a clearing write
      do_write(32'h0000_0180 | 32'h0000_0060, "R9 prep clear");
      @(negedge clk);
      rst     = 1'b1;
      wr_en   = 1'b1;
      wr_data = 32'h0000_01E0;
      @(negedge clk);
      rst   = 1'b0;
      wr_en = 1'b0;
      exp_lines = 2'b11;
      exp_rd    = '0;
      check("R9 reset wins lines", {30'd0, lines_out}, 32'd3);
      check("R9 reset wins readback", rd_data, 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule